// File: doc/BRIEF.md
# Register-Bank Target for a Two-Wire Serial Bus

This block is a bus target on a two-wire serial bus with a clock line and a bidirectional data line, as used by many control and configuration buses. It runs entirely in the fast system clock domain. Both lines are synchronized and filtered before their edges are decoded. The first byte after a start condition carries a 7-bit device address and a direction bit. When the address matches, the block answers on the ninth clock. On a write, the next byte selects one of eight 8-bit registers. Every later byte goes to the following register, with no need to send its number again.

The low subaddresses are status registers. Their values come from an input array, and they are read-only. The remaining subaddresses are control registers. They appear on a flat output bus and each has its own one-cycle write strobe. A read returns data starting at the subaddress that the last write selected. Such a read normally follows a write of the subaddress alone and a repeated start.

The data line is driven only through an open-drain pull-low enable. Several situations return the block to idle: a subaddress out of range, a stop condition at any point, or a master that declines a read byte. A start condition at any point begins a fresh address phase.

Top module: `i2c_regslave`

## Requirements
- R1: After reset, all control registers are zero, no write strobe is active and the pull-low enable `sda_oe_o` is 0.
- R2: A start (data falling while the clock is high) begins an address phase. Eight bits are taken most-significant first on clock rising edges: seven address bits, then the direction bit (0 means write, 1 means read). If the address equals `DEV_ADDR`, the block pulls the data line low for the whole ninth clock pulse.
- R3: A non-matching address is not acknowledged, and the block drives nothing until the next start.
- R4: In a write, the byte after the address byte is a subaddress. Values 0 to 7 are acknowledged and become the register pointer.
- R5: A subaddress of 8 or more is not acknowledged and returns the block to idle. Later bytes of that transfer are neither acknowledged nor stored.
- R6: Each further write byte is acknowledged, stored at the pointer, and then the pointer advances. Once the pointer reaches 7 it stays there, so extra bytes overwrite register 7. Control register k (subaddress k+2) sits at `ctrl_o[8k+7:8k]`.
- R7: Each stored write to control register k pulses `wr_stb_o[k]` for exactly one cycle, and at most one strobe bit is high in any cycle.
- R8: Subaddresses 0 and 1 are read-only. Writes to them are acknowledged but change no output and raise no strobe. Reads of them return `status_i[8s+7:8s]` for subaddress s.
- R9: A read (direction bit 1) returns bytes starting at the current pointer. Each byte the master acknowledges advances the pointer, and register 7 repeats once reached. A no-acknowledge ends the read, and the line is released.
- R10: Read data is sent most-significant first, and the block changes its drive only while the clock is low.
- R11: A stop (data rising while the clock is high) at any point returns the block to idle. A partly received byte is discarded.
- R12: A start at any point, even in the middle of a byte, restarts the address phase.
- R13: A stop followed by a start within one clock-high period is accepted, and the transfer that follows is served normally.
- R14: A pulse on either line that lasts fewer than `FILT_LEN` system cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| status_i | input | STAT_REGS*8 | Values of the read-only registers, subaddress 0 lowest |
| ctrl_o | output | CTRL_REGS*8 | Contents of the writable registers |
| wr_stb_o | output | CTRL_REGS | One-cycle strobe per writable register |

## Verification
A line change reaches the protocol state FILT_LEN+4 clock edges after it appears on a pin. With the default filter that is 7 edges, so the acknowledge and data drive change 7 cycles after a clock falling edge, and a stored register and its strobe follow one cycle later. The bench holds each bus phase for 10 system cycles. It samples the data line only in the middle of the clock-high phase and reads registers only after a full phase has passed, so every result has settled before it is checked. Strobes are counted on every cycle and compared with the bench's count of expected writes, which also catches a strobe that comes late or twice.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int unsigned REGS   = 8;
    localparam int unsigned DW     = 8;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned PTR_W  = $clog2(REGS);
    localparam int unsigned CNT_W  = $clog2(DW + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK
    } i2cs_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // saturating pointer advance: the last register repeats
    function automatic logic [PTR_W-1:0] ptr_adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(REGS - 1)) ? p : p + 1'b1;
    endfunction

    function automatic logic sub_valid(input logic [DW-1:0] b);
        return 32'(b) < REGS;
    endfunction

endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
    parameter int unsigned LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    logic [1:0]     sync_q;
    logic [LEN-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            hist_q  <= '1;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            hist_q <= {hist_q[LEN-2:0], sync_q[1]};
            if (&hist_q)
                clean_o <= 1'b1;
            else if (~|hist_q)
                clean_o <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.rise  = scl_i & ~scl_q;
        ev_o.fall  = ~scl_i & scl_q;
        ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
        ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
    import i2cs_pkg::*;
#(
    parameter int unsigned STAT_REGS = 2,
    localparam int unsigned CTRL_REGS = REGS - STAT_REGS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [PTR_W-1:0]        wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic [PTR_W-1:0]        rd_idx,
    output logic [DW-1:0]           rd_data,
    input  logic [STAT_REGS*DW-1:0] status_i,
    output logic [CTRL_REGS*DW-1:0] ctrl_o,
    output logic [CTRL_REGS-1:0]    stb_o
);
    logic [DW-1:0] val [REGS];

    for (genvar i = 0; i < REGS; i++) begin : g_reg
        if (i < STAT_REGS) begin : g_stat
            assign val[i] = status_i[i*DW +: DW];
        end else begin : g_ctl
            localparam int unsigned C = i - STAT_REGS;
            logic [DW-1:0] q;
            logic          s;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                    s <= 1'b0;
                end else begin
                    s <= wr_en && (wr_idx == PTR_W'(i));
                    if (wr_en && (wr_idx == PTR_W'(i)))
                        q <= wr_data;
                end
            end
            assign val[i]             = q;
            assign ctrl_o[C*DW +: DW] = q;
            assign stb_o[C]           = s;
        end
    end

    assign rd_data = val[rd_idx];
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2cs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR  = 7'h4A,
    parameter int unsigned       FILT_LEN  = 3,
    parameter int unsigned       STAT_REGS = 2,
    localparam int unsigned      CTRL_REGS = REGS - STAT_REGS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe_o,
    input  logic [STAT_REGS*DW-1:0] status_i,
    output logic [CTRL_REGS*DW-1:0] ctrl_o,
    output logic [CTRL_REGS-1:0]    wr_stb_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

    logic [1:0]       raw, clean;
    bus_ev_t          ev;
    i2cs_state_e      st;
    logic [DW-1:0]    shreg;
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] ptr;
    logic             rw, nack, wr_en;
    logic [DW-1:0]    rd_data;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2cs_filter #(.LEN(FILT_LEN)) u_flt (
            .clk(clk), .rst(rst), .raw_i(raw[g]), .clean_o(clean[g])
        );
    end

    i2cs_bus_events u_ev (
        .clk(clk), .rst(rst), .scl_i(clean[0]), .sda_i(clean[1]), .ev_o(ev)
    );

    i2cs_regbank #(.STAT_REGS(STAT_REGS)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(ptr), .wr_data(shreg),
        .rd_idx(ptr), .rd_data(rd_data),
        .status_i(status_i), .ctrl_o(ctrl_o), .stb_o(wr_stb_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            shreg    <= '0;
            cnt      <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            nack     <= 1'b0;
            sda_oe_o <= 1'b0;
            wr_en    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (ev.stop) begin
                st       <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else if (ev.start) begin
                st       <= ST_ADDR;
                cnt      <= '0;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR: begin
                        if (ev.rise && cnt != FULL) begin
                            shreg <= {shreg[DW-2:0], clean[1]};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == FULL) begin
                            if (shreg[DW-1:1] == DEV_ADDR) begin
                                sda_oe_o <= 1'b1;
                                rw       <= shreg[0];
                                st       <= ST_ADDR_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_SUB: begin
                        if (ev.rise && cnt != FULL) begin
                            shreg <= {shreg[DW-2:0], clean[1]};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == FULL) begin
                            if (sub_valid(shreg)) begin
                                sda_oe_o <= 1'b1;
                                ptr      <= shreg[PTR_W-1:0];
                                st       <= ST_SUB_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_WDAT: begin
                        if (ev.rise && cnt != FULL) begin
                            shreg <= {shreg[DW-2:0], clean[1]};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == FULL) begin
                            sda_oe_o <= 1'b1;
                            wr_en    <= 1'b1;
                            st       <= ST_WDAT_ACK;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            if (rw) begin
                                shreg    <= rd_data;
                                sda_oe_o <= ~rd_data[DW-1];
                                st       <= ST_RDAT;
                            end else begin
                                sda_oe_o <= 1'b0;
                                st       <= ST_SUB;
                            end
                        end
                    end
                    ST_SUB_ACK: begin
                        if (ev.fall) begin
                            sda_oe_o <= 1'b0;
                            cnt      <= '0;
                            st       <= ST_WDAT;
                        end
                    end
                    ST_WDAT_ACK: begin
                        if (ev.fall) begin
                            sda_oe_o <= 1'b0;
                            cnt      <= '0;
                            ptr      <= ptr_adv(ptr);
                            st       <= ST_WDAT;
                        end
                    end
                    ST_RDAT: begin
                        if (ev.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.fall) begin
                            if (cnt == FULL) begin
                                sda_oe_o <= 1'b0;
                                st       <= ST_RDAT_ACK;
                            end else begin
                                shreg    <= {shreg[DW-2:0], 1'b0};
                                sda_oe_o <= ~shreg[DW-2];
                            end
                        end
                    end
                    ST_RDAT_ACK: begin
                        if (ev.rise) begin
                            nack <= clean[1];
                            if (!clean[1])
                                ptr <= ptr_adv(ptr);
                        end else if (ev.fall) begin
                            if (nack) begin
                                sda_oe_o <= 1'b0;
                                st       <= ST_IDLE;
                            end else begin
                                shreg    <= rd_data;
                                sda_oe_o <= ~rd_data[DW-1];
                                cnt      <= '0;
                                st       <= ST_RDAT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
    import i2cs_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input logic             clk,
    input logic             rst,
    input i2cs_state_e      st,
    input bus_ev_t          ev,
    input logic             scl_f,
    input logic             oe,
    input logic [CW-1:0]    stb,
    input logic [CNT_W-1:0] cnt,
    input logic [DW-1:0]    shreg
);
    AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> st == ST_ADDR); // R12

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> st == ST_IDLE); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE |-> !oe); // R3

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> !scl_f); // R10

    AST_STB_IN_ACK: assert property (@(posedge clk) disable iff (rst)
        (|stb) |-> st == ST_WDAT_ACK); // R7

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb)); // R7

    AST_BAD_SUB: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUB && ev.fall && cnt == CNT_W'(DW) && !sub_valid(shreg))
        |=> (st == ST_IDLE && !oe)); // R5
endmodule

bind i2c_regslave i2cs_chk #(.CW(CTRL_REGS)) u_chk (
    .clk(clk), .rst(rst), .st(st), .ev(ev), .scl_f(clean[0]),
    .oe(sda_oe_o), .stb(wr_stb_o), .cnt(cnt), .shreg(shreg)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
    localparam logic [6:0] ADDR = 7'h4A;
    localparam int NS = 2;
    localparam int NC = 6;
    localparam int Q  = 10;

    logic clk = 0, rst = 1;
    logic scl_m = 1, sda_m = 1;
    logic scl_i, sda_i, sda_oe;
    logic [NS*8-1:0] status;
    logic [NC*8-1:0] ctrl;
    logic [NC-1:0]   stb;

    int total = 0, fails = 0;
    bit done = 0;
    logic [7:0] m [8];
    int exp_stb [NC];
    int got_stb [NC];
    logic [7:0] wbuf [16];
    int hi_changes = 0;
    logic prev_oe = 0, prev_scl = 1;

    assign scl_i = scl_m;
    assign sda_i = sda_m & ~sda_oe;

    i2c_regslave #(.DEV_ADDR(ADDR)) uut (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe_o(sda_oe),
        .status_i(status), .ctrl_o(ctrl), .wr_stb_o(stb)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NC; i++) if (stb[i]) got_stb[i]++;
            if (scl_i && prev_scl && sda_oe != prev_oe) hi_changes++;
        end
        prev_oe  <= sda_oe;
        prev_scl <= scl_i;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_val(input int s);
        return (s < NS) ? status[s*8 +: 8] : m[s];
    endfunction

    function automatic int adv(input int p);
        return (p == 7) ? 7 : p + 1;
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q);
    endtask

    task automatic bus_stop;
        scl_m = 0; wt(Q); sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i];
            if (glitch && i == 4) begin
                wt(4); scl_m = 1; wt(1); scl_m = 0; wt(5);
            end else wt(Q);
            scl_m = 1;
            if (glitch && i == 3) begin
                wt(5); sda_m = ~sda_m; wt(1); sda_m = ~sda_m; wt(14);
            end else wt(2*Q);
            scl_m = 0; wt(Q);
        end
    endtask

    task automatic wbyte(input logic [7:0] b, input bit glitch, output bit ack);
        send_bits(b, 8, glitch);
        sda_m = 1; wt(Q); scl_m = 1; wt(Q);
        ack = ~sda_i;
        wt(Q); scl_m = 0; wt(Q);
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] d);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q); scl_m = 1; wt(Q); d[i] = sda_i; wt(Q); scl_m = 0; wt(Q);
        end
        sda_m = ~give_ack; wt(Q); scl_m = 1; wt(2*Q); scl_m = 0; wt(Q); sda_m = 1;
    endtask

    task automatic chk_ctrl(input string req);
        for (int i = 0; i < NC; i++)
            chk(ctrl[i*8 +: 8] == m[i+NS], req, ctrl[i*8 +: 8], m[i+NS]);
    endtask

    task automatic chk_stb(input string req);
        for (int i = 0; i < NC; i++) chk(got_stb[i] == exp_stb[i], req, got_stb[i], exp_stb[i]);
    endtask

    // full write transaction from wbuf[0..n-1]
    task automatic do_write(input int sub, input int n, input bit glitch);
        bit a;
        int p = sub;
        bus_start;
        wbyte({ADDR, 1'b0}, 0, a); chk(a, "R2 addr ack", a, 1);
        wbyte(8'(sub), 0, a);      chk(a, "R4 sub ack", a, 1);
        for (int k = 0; k < n; k++) begin
            wbyte(wbuf[k], glitch && k == 0, a);
            chk(a, "R6 data ack", a, 1);
            if (p >= NS) begin m[p] = wbuf[k]; exp_stb[p-NS]++; end
            p = adv(p);
        end
        bus_stop;
    endtask

    task automatic do_read(input int sub, input int n);
        bit a;
        logic [7:0] d;
        int p = sub;
        bus_start;
        wbyte({ADDR, 1'b0}, 0, a); chk(a, "R2 addr ack", a, 1);
        wbyte(8'(sub), 0, a);      chk(a, "R4 sub ack", a, 1);
        bus_start;
        wbyte({ADDR, 1'b1}, 0, a); chk(a, "R9 read addr ack", a, 1);
        for (int k = 0; k < n; k++) begin
            rbyte(k < n - 1, d);
            chk(d == exp_val(p), "R9 R10 read data", d, exp_val(p));
            p = adv(p);
        end
        bus_stop;
        chk(sda_oe == 0, "R9 released after nack", sda_oe, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        bit a;
        int unused;
        unused = $urandom(32'h5eed);
        for (int i = 0; i < 8; i++) m[i] = 0;
        for (int i = 0; i < NC; i++) begin exp_stb[i] = 0; got_stb[i] = 0; end
        status = 16'hA55A;
        wt(5); rst = 0; wt(5);

        // R1 reset state
        chk(ctrl == 0, "R1 ctrl reset", ctrl, 0);
        chk(stb == 0, "R1 strobe reset", stb, 0);
        chk(sda_oe == 0, "R1 oe reset", sda_oe, 0);

        // single and burst writes, read back
        wbuf[0] = 8'h3C; do_write(4, 1, 0); chk_ctrl("R6 single write"); chk_stb("R7 single");
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        do_write(5, 4, 0); chk_ctrl("R6 write clamp at reg 7"); chk_stb("R7 burst");
        do_read(4, 5);

        // R8 read-only writes ignored, reads return status
        wbuf[0] = 8'hEE; wbuf[1] = 8'hDD; wbuf[2] = 8'h99;
        do_write(0, 3, 0); chk_ctrl("R8 read-only write"); chk_stb("R8 strobes");
        do_read(0, 3);

        // R3 wrong address
        bus_start;
        wbyte({7'h13, 1'b0}, 0, a); chk(!a, "R3 no ack", a, 0);
        wbyte(8'h03, 0, a);         chk(!a, "R3 ignored", a, 0);
        wbyte(8'hFF, 0, a);         chk(!a, "R3 ignored data", a, 0);
        bus_stop; chk_ctrl("R3 regs kept");

        // R5 invalid subaddress
        bus_start;
        wbyte({ADDR, 1'b0}, 0, a); chk(a, "R2 addr ack", a, 1);
        wbyte(8'h08, 0, a);        chk(!a, "R5 sub 8 nack", a, 0);
        wbyte(8'h55, 0, a);        chk(!a, "R5 data ignored", a, 0);
        bus_stop; chk_ctrl("R5 regs kept"); chk_stb("R5 strobes");
        bus_start;
        wbyte({ADDR, 1'b0}, 0, a); chk(a, "R2 addr ack", a, 1);
        wbyte(8'hC5, 0, a);        chk(!a, "R5 sub C5 nack", a, 0);
        bus_stop;

        // R11 stop in mid byte
        bus_start;
        wbyte({ADDR, 1'b0}, 0, a); wbyte(8'h05, 0, a);
        send_bits(8'h00, 3, 0); bus_stop;
        chk_ctrl("R11 partial byte dropped"); chk_stb("R11 strobes");
        wbuf[0] = 8'h5A; do_write(5, 1, 0); chk_ctrl("R11 next transfer");

        // R12 start in mid byte
        bus_start;
        wbyte({ADDR, 1'b0}, 0, a); wbyte(8'h04, 0, a);
        send_bits(8'h00, 3, 0);
        bus_start;
        wbyte({ADDR, 1'b0}, 0, a); chk(a, "R12 restart addr ack", a, 1);
        wbyte(8'h06, 0, a); wbyte(8'h77, 0, a); chk(a, "R12 data ack", a, 1);
        m[6] = 8'h77; exp_stb[4]++;
        bus_stop; chk_ctrl("R12 regs"); chk_stb("R12 strobes");

        // R13 stop then start in one clock-high period
        bus_start;
        wbyte({ADDR, 1'b0}, 0, a); wbyte(8'h03, 0, a); wbyte(8'h81, 0, a);
        m[3] = 8'h81; exp_stb[1]++;
        scl_m = 0; wt(Q); sda_m = 0; wt(Q); scl_m = 1; wt(Q);
        sda_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q);
        wbyte({ADDR, 1'b0}, 0, a); chk(a, "R13 addr ack", a, 1);
        wbyte(8'h07, 0, a); wbyte(8'h42, 0, a); chk(a, "R13 data ack", a, 1);
        m[7] = 8'h42; exp_stb[5]++;
        bus_stop; chk_ctrl("R13 regs"); chk_stb("R13 strobes");

        // R14 glitches on both lines
        wbuf[0] = 8'hB9; do_write(2, 1, 1); chk_ctrl("R14 glitch filtered"); chk_stb("R14 strobes");

        // random mix
        for (int it = 0; it < 12; it++) begin
            int s, n;
            status = 16'($urandom);
            s = $urandom_range(0, 7); n = $urandom_range(1, 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(s, n, 0);
            chk_ctrl("R6 random write");
            s = $urandom_range(0, 7); n = $urandom_range(1, 5);
            do_read(s, n);
        end
        chk_stb("R7 random strobes");
        chk(hi_changes == 0, "R10 drive change with clock high", hi_changes, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule